// File: doc/BRIEF.md
# Two-Wire EEPROM Write Receiver

This block is the receiving front end of a small serial EEPROM on a two-wire bus. It samples the bus clock and data lines with the system clock and finds Start and Stop conditions. It takes in the control byte and compares it with the fixed device code and the chip-select straps. It then takes in the word address and the data bytes that follow. For every byte it accepts, it pulls SDA low through an open-drain enable. Read transfers, clock stretching and 10-bit addressing are not handled.

Accepted traffic goes to a downstream page-buffer block as one-cycle strobes:
- `wr_start` marks an accepted write control byte.
- `byte_valid` carries each received byte, with `byte_is_addr` separating the word address from data.
- `wr_stop` marks a Stop that commits at least one data byte.

While the memory is busy with an internal write cycle, the block does not acknowledge control bytes, so a bus master can poll for completion. It has no knowledge of address protection: every address and data byte is acknowledged in the same way.

The controller is a state machine with seven states:
- `S_IDLE`: waits for a Start.
- `S_CTRL`: receives the control byte.
- `S_CTRL_ACK`: drives the control acknowledge.
- `S_ADDR`: receives the word address.
- `S_ADDR_ACK`: drives the address acknowledge.
- `S_DATA`: receives a data byte.
- `S_DATA_ACK`: drives the data acknowledge.

Transitions:
- A Start moves any state to `S_CTRL`.
- A Stop moves any state to `S_IDLE`.
- The falling SCL edge after the eighth bit moves each receive state either to its acknowledge state or, for a refused control byte, to `S_IDLE`.
- The falling SCL edge ending the ninth pulse moves `S_CTRL_ACK` to `S_ADDR`, `S_ADDR_ACK` to `S_DATA`, and `S_DATA_ACK` back to `S_DATA`.

Top module: `eep_wr_slave`

## Requirements
- R1: A Start (SDA falling while SCL is high, seen on the synchronised lines) in any state begins reception of a new control byte, with the bits taken MSB first on rising SCL edges.
- R2: A control byte whose bits 7..4 are 4'b1010, whose bits 3..1 equal `strap_cs`, and whose bit 0 is 0 is acknowledged (`sda_oe` high through the ninth SCL high phase). It produces one `wr_start` pulse.
- R3: A control byte with the wrong device code or with chip-select bits that differ from `strap_cs` is not acknowledged. Every following byte up to the next Start is then ignored: no acknowledge and no strobes.
- R4: A control byte with bit 0 set (a read) is not acknowledged and produces no `wr_start`.
- R5: While `busy` is high at the end of the control byte, the control byte is not acknowledged and no `wr_start` is produced.
- R6: The byte after an accepted control byte is acknowledged and presented as one `byte_valid` pulse with `byte_is_addr` = 1. This holds for every address value.
- R7: Each later byte before a Stop is acknowledged and presented as one `byte_valid` pulse with `byte_is_addr` = 0 and its value on `byte_data`. The strobes `wr_start`, `byte_valid` and `wr_stop` are never high together.
- R8: A Stop (SDA rising while SCL is high) that follows at least one data byte gives one `wr_stop` pulse. A Stop with no data byte since the last Start gives none.
- R9: A repeated Start without a Stop gives no `wr_stop` and discards the pending transfer. The next accepted control byte produces a fresh `wr_start`.
- R10: After reset, `sda_oe` is low and no strobe is active.
- R11: `sda_oe` only changes while the synchronised SCL is low. It is released after the falling edge that ends the ninth pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| strap_cs | input | 3 | Chip-select strap pins compared with control bits 3..1 |
| busy | input | 1 | Internal write cycle in progress |
| sda_oe | output | 1 | Open-drain enable; high pulls SDA low |
| wr_start | output | 1 | Pulse: write control byte accepted |
| byte_valid | output | 1 | Pulse: a received byte is on byte_data |
| byte_is_addr | output | 1 | Qualifies byte_valid: 1 for the word address |
| byte_data | output | 8 | Received byte |
| wr_stop | output | 1 | Pulse: Stop that commits the received data |

## Verification
A wrong state shows at the ports within one byte time. An acknowledge lands in the wrong ninth pulse or goes missing. An address comes out flagged as data, or the reverse. A Stop pulse appears or is missing after the next Stop condition. The scoreboard predicts the exact ordered stream of strobes for each transaction, and each ninth pulse is sampled for the expected acknowledge. A bit-count or byte-capture slip therefore shows as a wrong `byte_data` value or a shifted acknowledge in the same byte. A state that fails to drop back to idle shows as acknowledges given to traffic that should be ignored.

// File: rtl/eep_pkg.sv
package eep_pkg;
    localparam int BYTE_W = 8;
    localparam int CS_W = 3;
    localparam int CODE_W = BYTE_W - 1 - CS_W;
    localparam logic [CODE_W-1:0] DEV_CODE = 4'b1010;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CTRL,
        S_CTRL_ACK,
        S_ADDR,
        S_ADDR_ACK,
        S_DATA,
        S_DATA_ACK
    } fsm_t;
endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q,
    output logic q_prev
);
    logic [STAGES-1:0] pipe;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pipe[i] <= 1'b1;
                end else if (i == 0) begin
                    pipe[i] <= d_in;
                end else begin
                    pipe[i] <= pipe[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_prev <= 1'b1;
        end else begin
            q_prev <= pipe[STAGES-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/eep_bus_events.sv
module eep_bus_events (
    input  logic scl_q,
    input  logic scl_p,
    input  logic sda_q,
    input  logic sda_p,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_high;

    always_comb begin
        scl_high  = scl_q & scl_p;
        scl_rise  = scl_q & ~scl_p;
        scl_fall  = ~scl_q & scl_p;
        start_det = scl_high & sda_p & ~sda_q;
        stop_det  = scl_high & ~sda_p & sda_q;
    end
endmodule

// File: rtl/eep_bit_shift.sv
module eep_bit_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] shreg,
    output logic         full
);
    localparam int CNT_W = $clog2(W + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(W);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            shreg <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (shift_en && !full) begin
            cnt   <= cnt + 1'b1;
            shreg <= {shreg[W-2:0], bit_in};
        end
    end

    assign full = (cnt == CNT_MAX);
endmodule

// File: rtl/eep_wr_slave.sv
module eep_wr_slave
    import eep_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [CS_W-1:0]   strap_cs,
    input  logic              busy,
    output logic              sda_oe,
    output logic              wr_start,
    output logic              byte_valid,
    output logic              byte_is_addr,
    output logic [BYTE_W-1:0] byte_data,
    output logic              wr_stop
);
    logic scl_q, scl_p, sda_q, sda_p;
    logic scl_rise, scl_fall, start_det, stop_det;
    logic [BYTE_W-1:0] shreg;
    logic full, byte_done, in_ack, bit_clr, ctrl_ok, data_seen;
    fsm_t st, st_nx;

    eep_line_sync #(.STAGES(SYNC_STAGES)) u_scl (
        .clk(clk), .rst_n(rst_n), .d_in(scl_in), .q(scl_q), .q_prev(scl_p)
    );

    eep_line_sync #(.STAGES(SYNC_STAGES)) u_sda (
        .clk(clk), .rst_n(rst_n), .d_in(sda_in), .q(sda_q), .q_prev(sda_p)
    );

    eep_bus_events u_evt (
        .scl_q(scl_q), .scl_p(scl_p), .sda_q(sda_q), .sda_p(sda_p),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    eep_bit_shift #(.W(BYTE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .clr(bit_clr), .shift_en(scl_rise),
        .bit_in(sda_q), .shreg(shreg), .full(full)
    );

    assign in_ack    = (st == S_CTRL_ACK) || (st == S_ADDR_ACK) || (st == S_DATA_ACK);
    assign byte_done = full & scl_fall;
    assign bit_clr   = start_det | stop_det | (in_ack & scl_fall);
    assign ctrl_ok   = (shreg[BYTE_W-1 -: CODE_W] == DEV_CODE) &&
                       (shreg[CS_W:1] == strap_cs) && !shreg[0] && !busy;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= S_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    // next-state decode
    always_comb begin
        st_nx = st;
        if (start_det) begin
            st_nx = S_CTRL;
        end else if (stop_det) begin
            st_nx = S_IDLE;
        end else begin
            unique case (st)
                S_IDLE:     st_nx = S_IDLE;
                S_CTRL:     if (byte_done) st_nx = ctrl_ok ? S_CTRL_ACK : S_IDLE;
                S_CTRL_ACK: if (scl_fall)  st_nx = S_ADDR;
                S_ADDR:     if (byte_done) st_nx = S_ADDR_ACK;
                S_ADDR_ACK: if (scl_fall)  st_nx = S_DATA;
                S_DATA:     if (byte_done) st_nx = S_DATA_ACK;
                S_DATA_ACK: if (scl_fall)  st_nx = S_DATA;
                default:    st_nx = S_IDLE;
            endcase
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe       <= 1'b0;
            wr_start     <= 1'b0;
            byte_valid   <= 1'b0;
            byte_is_addr <= 1'b0;
            byte_data    <= '0;
            wr_stop      <= 1'b0;
            data_seen    <= 1'b0;
        end else begin
            sda_oe     <= (st_nx == S_CTRL_ACK) || (st_nx == S_ADDR_ACK) ||
                          (st_nx == S_DATA_ACK);
            wr_start   <= 1'b0;
            byte_valid <= 1'b0;
            wr_stop    <= 1'b0;
            if (start_det) begin
                data_seen <= 1'b0;
            end else if (stop_det) begin
                wr_stop   <= data_seen;
                data_seen <= 1'b0;
            end else if (byte_done) begin
                unique case (st)
                    S_CTRL: wr_start <= ctrl_ok;
                    S_ADDR: begin
                        byte_valid   <= 1'b1;
                        byte_is_addr <= 1'b1;
                        byte_data    <= shreg;
                    end
                    S_DATA: begin
                        byte_valid   <= 1'b1;
                        byte_is_addr <= 1'b0;
                        byte_data    <= shreg;
                        data_seen    <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/eep_wr_slave_chk.sv
module eep_wr_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic scl_q,
    input logic start_det,
    input logic stop_det,
    input logic sda_oe,
    input logic wr_start,
    input logic byte_valid,
    input logic wr_stop
);
    AST_START_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |-> sda_oe); // R2

    AST_START_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |-> !$past(busy)); // R5

    AST_BYTE_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> sda_oe); // R6

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_start, byte_valid, wr_stop})); // R7

    AST_STOP_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stop |-> !sda_oe); // R8

    AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((sda_oe != $past(sda_oe)) && !$past(start_det) && !$past(stop_det))
        |-> !$past(scl_q)); // R11
endmodule

bind eep_wr_slave eep_wr_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .scl_q(scl_q),
    .start_det(start_det), .stop_det(stop_det), .sda_oe(sda_oe),
    .wr_start(wr_start), .byte_valid(byte_valid), .wr_stop(wr_stop)
);

// File: tb/sim_eep_wr_slave.sv
module sim_eep_wr_slave;
    localparam int Q = 8;
    localparam logic [2:0] CS = 3'b101;
    localparam logic [7:0] CTRL_W = {4'b1010, CS, 1'b0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic busy = 1'b0;
    logic sda_bus;
    logic sda_oe, wr_start, byte_valid, byte_is_addr, wr_stop;
    logic [7:0] byte_data;

    int n_chk = 0;
    int n_bad = 0;

    // expected strobe stream: kind 0 start, 1 address, 2 data, 3 stop
    int         q_kind[$];
    logic [7:0] q_data[$];
    string      q_tag[$];

    always #2 clk = ~clk;

    assign sda_bus = m_sda & ~sda_oe;

    eep_wr_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus),
        .strap_cs(CS), .busy(busy), .sda_oe(sda_oe), .wr_start(wr_start),
        .byte_valid(byte_valid), .byte_is_addr(byte_is_addr),
        .byte_data(byte_data), .wr_stop(wr_stop)
    );

    task automatic wait_q(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_item(input int kind, input logic [7:0] d, input string tag);
        q_kind.push_back(kind);
        q_data.push_back(d);
        q_tag.push_back(tag);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_start;
        m_sda = 1'b1; wait_q(Q);
        m_scl = 1'b1; wait_q(Q);
        m_sda = 1'b0; wait_q(Q);
        m_scl = 1'b0; wait_q(Q);
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; wait_q(Q);
        m_scl = 1'b1; wait_q(Q);
        m_sda = 1'b1; wait_q(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wait_q(Q);
            m_scl = 1'b1; wait_q(Q);
            m_scl = 1'b0;
        end
        m_sda = 1'b1; wait_q(Q);
        m_scl = 1'b1; wait_q(Q/2);
        check(sda_oe == exp_ack, tag, sda_oe, exp_ack);
        wait_q(Q/2);
        m_scl = 1'b0; wait_q(Q);
        check(sda_oe == 1'b0, "R11", sda_oe, 0);
    endtask

    // monitor: pop expected strobes as the design produces them
    always @(negedge clk) begin
        if (rst_n && (wr_start || byte_valid || wr_stop)) begin
            int k;
            k = wr_start ? 0 : (byte_valid ? (byte_is_addr ? 1 : 2) : 3);
            if (q_kind.size() == 0) begin
                check(1'b0, "R3 unexpected strobe", k, 255);
            end else begin
                int ek;
                logic [7:0] ed;
                string et;
                ek = q_kind.pop_front();
                ed = q_data.pop_front();
                et = q_tag.pop_front();
                check(k == ek, et, k, ek);
                if (ek == 1 || ek == 2) check(byte_data == ed, et, byte_data, ed);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait_q(5);
        check(sda_oe == 1'b0, "R10", sda_oe, 0);
        check({wr_start, byte_valid, wr_stop} == 3'b000, "R10",
              {wr_start, byte_valid, wr_stop}, 0);
        rst_n = 1'b1;
        wait_q(5);
        check(sda_oe == 1'b0, "R10", sda_oe, 0);

        // R1 R2 R6 R7 R8: plain write of two data bytes
        bus_start;
        expect_item(0, 8'h00, "R2");
        send_byte(CTRL_W, 1'b1, "R2");
        expect_item(1, 8'h37, "R6");
        send_byte(8'h37, 1'b1, "R6");
        expect_item(2, 8'h5C, "R7");
        send_byte(8'h5C, 1'b1, "R7");
        expect_item(2, 8'hA3, "R7");
        send_byte(8'hA3, 1'b1, "R7");
        expect_item(3, 8'h00, "R8");
        bus_stop;
        wait_q(2*Q);

        // R3: chip-select mismatch, later byte ignored
        bus_start;
        send_byte({4'b1010, 3'b100, 1'b0}, 1'b0, "R3");
        send_byte(8'h12, 1'b0, "R3");
        send_byte(8'h34, 1'b0, "R3");
        bus_stop;
        wait_q(2*Q);

        // R3: wrong device code
        bus_start;
        send_byte({4'b1011, CS, 1'b0}, 1'b0, "R3");
        bus_stop;

        // R4: read request refused
        bus_start;
        send_byte({4'b1010, CS, 1'b1}, 1'b0, "R4");
        bus_stop;

        // R5: busy polling
        busy = 1'b1;
        bus_start;
        send_byte(CTRL_W, 1'b0, "R5");
        bus_stop;
        busy = 1'b0;
        bus_start;
        expect_item(0, 8'h00, "R5");
        send_byte(CTRL_W, 1'b1, "R5");

        // R8: stop after address only commits nothing
        expect_item(1, 8'hF0, "R6");
        send_byte(8'hF0, 1'b1, "R6");
        bus_stop;
        wait_q(2*Q);

        // R9: repeated start discards and restarts
        bus_start;
        expect_item(0, 8'h00, "R9");
        send_byte(CTRL_W, 1'b1, "R9");
        expect_item(1, 8'h40, "R9");
        send_byte(8'h40, 1'b1, "R9");
        expect_item(2, 8'h11, "R9");
        send_byte(8'h11, 1'b1, "R9");
        bus_start;
        expect_item(0, 8'h00, "R9");
        send_byte(CTRL_W, 1'b1, "R1");
        expect_item(1, 8'h80, "R9");
        send_byte(8'h80, 1'b1, "R9");
        expect_item(2, 8'hFF, "R7");
        send_byte(8'hFF, 1'b1, "R7");
        expect_item(2, 8'h00, "R7");
        send_byte(8'h00, 1'b1, "R7");
        expect_item(3, 8'h00, "R8");
        bus_stop;
        wait_q(4*Q);

        check(q_kind.size() == 0, "R8 missing strobes", q_kind.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule